// File: doc/BRIEF.md
# BCH Error-Locator Root Search

This block takes the error-locator polynomial of a shortened binary BCH code over GF(2^13) and finds which codeword positions it marks. A start pulse latches eight locator coefficients (those of x^1 through x^8; the constant term is taken as 1), the number of errors the solver expects, and a mode bit. The mode bit picks 4-error correction (52 parity bits) or 8-error correction (104 parity bits). The block then evaluates the polynomial at one field element per clock. Each evaluation register is multiplied by a fixed power of the inverse primitive element, using constant GF(2^13) multipliers.

A root found at step i is turned into a bit address inside the 512-byte data area. That address comes out with a one-cycle strobe. Roots that land in the parity region are skipped and not counted. The search ends as soon as the number of reported roots equals the expected count, or after the last field element. It finishes with a one-cycle done pulse and a success flag. Correcting the data bits is left to the logic that receives the addresses.

Top module: `bch_chien_search`

## Requirements
- R1: After reset, `busy`, `loc_valid` and `done` are low, and `loc_valid` is never high while `busy` is low.
- R2: A `start` pulse loads the inputs on that clock edge, and `busy` is high from the next cycle until the cycle with `done`. Step i is evaluated on the i-th clock edge after the start edge. A root at step i raises `loc_valid` in the cycle that follows that edge.
- R3: The field uses x^13+x^4+x^3+x+1. Register j (0..7) starts at the coefficient of x^(j+1), which is `coef[13j+12:13j]`. On each step, register j is multiplied by alpha^-(j+1), where alpha^-1 = 0x100D. A step is a root when 1 XOR all eight registers is zero, with the sum taken before the update.
- R4: For a reported root at step i, let p = i-1 and form q by replacing the low three bits of p with 7 minus those bits. Then `loc` = (4095 + 2P - q) mod 16384, where P is 52 when `mode8`=0 and 104 when `mode8`=1.
- R5: A root at a step i below 2P is neither reported nor counted.
- R6: Once the count of reported roots equals the expected count, `done` is raised in the next cycle and no further step is evaluated.
- R7: If the expected count is never reached, steps run up to 8191. `done` then comes on the 8192nd edge after start, with `ok` low.
- R8: `ok` is high exactly when the reported count equals the expected count. An expected count of 0 gives `done` on the first edge after start, with `ok` high.
- R9: `loc_na` is high with `loc_valid` exactly when `loc` is 4096 or more, meaning the address lies outside the data area.
- R10: A `start` pulse while `busy` is high abandons the running search without a `done` pulse and begins a new search from the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load inputs and begin a search |
| mode8 | input | 1 | 0: 4-error mode, 1: 8-error mode |
| coef | input | 104 | Locator coefficients of x^1..x^8, 13 bits each, x^1 in the low bits |
| exp_cnt | input | 4 | Number of roots the solver expects |
| busy | output | 1 | Search in progress |
| loc_valid | output | 1 | One-cycle strobe for `loc` and `loc_na` |
| loc | output | 14 | Bit address of a found error |
| loc_na | output | 1 | Address lies outside the data area |
| done | output | 1 | One-cycle end-of-search pulse |
| ok | output | 1 | Root count matched expectation (valid from `done`) |

## Verification
Two events can share a clock edge: a restart pulse and a search step that would report a root or reach the expected count. The bench issues a fresh `start` partway through a running search, at a moment when the first polynomial still has roots ahead. It then requires that no `done` appears before the second search ends. It also requires that every address and every strobe cycle afterwards matches the second polynomial alone, counted from the restart edge.

// File: rtl/bch_chien_pkg.sv
package bch_chien_pkg;
  localparam int GF_W = 13;
  localparam logic [GF_W:0] GF_POLY = 14'h201B;
  localparam logic [GF_W-1:0] ALPHA_INV = 13'h100D;

  // product in GF(2^13), multiplier bits consumed from the top down
  function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a, input logic [GF_W-1:0] b);
    logic [GF_W:0] acc;
    acc = '0;
    for (int k = GF_W - 1; k >= 0; k--) begin
      acc = {acc[GF_W-1:0], 1'b0};
      if (acc[GF_W]) acc = acc ^ GF_POLY;
      if (a[k]) acc = acc ^ {1'b0, b};
    end
    return acc[GF_W-1:0];
  endfunction

  function automatic logic [GF_W-1:0] gf_pow(input logic [GF_W-1:0] base, input int n);
    logic [GF_W-1:0] r;
    r = GF_W'(1);
    for (int k = 0; k < n; k++) r = gf_mul(r, base);
    return r;
  endfunction

  // step index -> data bit address (mod 2^14)
  function automatic logic [GF_W:0] data_loc(input logic [GF_W:0] step, input int par, input int data_bits);
    logic [GF_W:0] p, pos;
    p = step - 14'd1;
    pos = {p[GF_W:3], 3'd7 - p[2:0]};
    return 14'(data_bits - 1 + 2 * par) - pos;
  endfunction
endpackage

// File: rtl/bch_chien_cell.sv
module bch_chien_cell import bch_chien_pkg::*; #(
  parameter int POWER = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [GF_W-1:0] coef_in,
  output logic [GF_W-1:0] val
);
  localparam logic [GF_W-1:0] STEP_MUL = gf_pow(ALPHA_INV, POWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (load) val <= coef_in;
    else if (adv)  val <= gf_mul(val, STEP_MUL);
  end
endmodule

// File: rtl/bch_chien_map.sv
module bch_chien_map import bch_chien_pkg::*; #(
  parameter int DATA_BITS = 4096,
  parameter int PAR_T4    = 52,
  parameter int PAR_T8    = 104
) (
  input  logic [GF_W:0] step,
  input  logic          mode8,
  output logic [GF_W:0] loc,
  output logic          loc_na,
  output logic [GF_W:0] min_step
);
  int par;
  always_comb begin
    par      = mode8 ? PAR_T8 : PAR_T4;
    min_step = 14'(2 * par);
    loc      = data_loc(step, par, DATA_BITS);
    loc_na   = (loc >= 14'(DATA_BITS));
  end
endmodule

// File: rtl/bch_chien_search.sv
module bch_chien_search import bch_chien_pkg::*; #(
  parameter int DATA_BITS = 4096,
  parameter int PAR_T4    = 52,
  parameter int PAR_T8    = 104,
  parameter int NCOEF     = 8,
  parameter int CNT_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode8,
  input  logic [NCOEF*GF_W-1:0]   coef,
  input  logic [CNT_W-1:0]        exp_cnt,
  output logic                    busy,
  output logic                    loc_valid,
  output logic [GF_W:0]           loc,
  output logic                    loc_na,
  output logic                    done,
  output logic                    ok
);
  localparam int SW = GF_W + 1;
  localparam logic [SW-1:0] LAST_STEP = 14'((1 << GF_W) - 1);

  logic [SW-1:0]    step_q;
  logic [CNT_W-1:0] cnt_q, exp_q;
  logic             mode_q;
  logic [GF_W-1:0]  term [NCOEF];
  logic [GF_W-1:0]  eval_sum;
  logic             root_hit, search_end, step_go, record;
  logic [SW-1:0]    map_loc_w, min_step;
  logic             map_na;

  for (genvar j = 0; j < NCOEF; j++) begin : g_cell
    bch_chien_cell #(.POWER(j + 1)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .adv     (step_go),
      .coef_in (coef[j*GF_W +: GF_W]),
      .val     (term[j])
    );
  end

  always_comb begin
    eval_sum = GF_W'(1);
    for (int j = 0; j < NCOEF; j++) eval_sum = eval_sum ^ term[j];
  end

  assign root_hit   = (eval_sum == '0);
  assign search_end = (cnt_q == exp_q) || (step_q > LAST_STEP);
  assign step_go    = busy && !start && !search_end;
  assign record     = step_go && root_hit && (step_q >= min_step);

  bch_chien_map #(.DATA_BITS(DATA_BITS), .PAR_T4(PAR_T4), .PAR_T8(PAR_T8)) u_map (
    .step     (step_q),
    .mode8    (mode_q),
    .loc      (map_loc_w),
    .loc_na   (map_na),
    .min_step (min_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; ok <= 1'b0;
      loc_valid <= 1'b0; loc <= '0; loc_na <= 1'b0;
      step_q <= '0; cnt_q <= '0; exp_q <= '0; mode_q <= 1'b0;
    end else begin
      done      <= 1'b0;
      loc_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        step_q <= 14'd1;
        cnt_q  <= '0;
        exp_q  <= exp_cnt;
        mode_q <= mode8;
      end else if (busy) begin
        if (search_end) begin
          busy <= 1'b0;
          done <= 1'b1;
          ok   <= (cnt_q == exp_q);
        end else begin
          step_q <= step_q + 14'd1;
          if (record) begin
            cnt_q     <= cnt_q + CNT_W'(1);
            loc_valid <= 1'b1;
            loc       <= map_loc_w;
            loc_na    <= map_na;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bch_chien_search_sva.sv
module bch_chien_search_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        loc_valid,
  input logic [13:0] loc,
  input logic        loc_na,
  input logic [13:0] step_q,
  input logic [3:0]  cnt_q,
  input logic [3:0]  exp_q
);
  a_r1_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> busy);
  a_r2_start_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= exp_q));
  a_r7_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q <= 14'd8192));
  a_r9_inside_data: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_na) |-> (loc < 14'd4096));
  a_r10_no_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind bch_chien_search bch_chien_search_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .loc_valid(loc_valid), .loc(loc), .loc_na(loc_na),
  .step_q(step_q), .cnt_q(cnt_q), .exp_q(exp_q)
);

// File: tb/bch_chien_search_bench.sv
module bch_chien_search_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode8 = 1'b0;
  logic [103:0] coef = '0;
  logic [3:0] exp_cnt = '0;
  logic busy, loc_valid, loc_na, done, ok;
  logic [13:0] loc;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bch_chien_search u_bch_chien_search (
    .clk(clk), .rst_n(rst_n), .start(start), .mode8(mode8), .coef(coef),
    .exp_cnt(exp_cnt), .busy(busy), .loc_valid(loc_valid), .loc(loc),
    .loc_na(loc_na), .done(done), .ok(ok));

  int rts[8]; int nrt;
  int e_step[8], e_loc[8], e_na[8]; int n_exp, done_k, ok_exp, exp_n;

  task automatic chk(input string req, input bit good, input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // LSB-first field product
  function automatic int fmul(input int a, input int b);
    int r = 0, x = b;
    for (int k = 0; k < 13; k++) begin
      if (a[k]) r = r ^ x;
      x = x << 1;
      if (x[13]) x = x ^ 'h201B;
    end
    return r;
  endfunction

  function automatic int apow(input int e);
    int r = 1;
    for (int k = 0; k < e; k++) r = fmul(r, 2);
    return r;
  endfunction

  // locator with roots alpha^-(i-1) for every listed step i; expectations
  task automatic prepare(input bit m8, input int expc);
    int lam[9]; int par, cnt, last, t;
    for (int k = 0; k < 9; k++) lam[k] = 0;
    lam[0] = 1;
    for (int a = 0; a < nrt; a++)
      for (int b = a + 1; b < nrt; b++)
        if (rts[b] < rts[a]) begin t = rts[a]; rts[a] = rts[b]; rts[b] = t; end
    for (int r = 0; r < nrt; r++) begin
      int beta = apow(rts[r] - 1);
      for (int k = 8; k >= 1; k--) lam[k] = lam[k] ^ fmul(beta, lam[k-1]);
    end
    for (int j = 0; j < 8; j++) coef[j*13 +: 13] = 13'(lam[j+1]);
    mode8 = m8; exp_cnt = 4'(expc); exp_n = expc;
    par = m8 ? 104 : 52; cnt = 0; last = 0;
    for (int r = 0; r < nrt; r++) begin
      if (cnt == expc) break;
      if (rts[r] >= 2 * par) begin
        e_step[cnt] = rts[r];
        e_loc[cnt]  = (4095 + 2 * par - ((rts[r] - 1) ^ 7)) & 16383;
        e_na[cnt]   = (e_loc[cnt] >= 4096);
        cnt++; last = rts[r];
      end
    end
    n_exp = cnt;
    if (cnt == expc) begin done_k = last + 1; ok_exp = 1; end
    else begin done_k = 8192; ok_exp = 0; end
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", busy === 1'b1, busy, 1);
  endtask

  task automatic collect();
    int idx = 0; bit seen = 0;
    for (int k = 1; k <= 8300; k++) begin
      @(negedge clk);
      if (loc_valid) begin
        if (idx < n_exp) begin
          chk("R2 strobe step", k == e_step[idx], k, e_step[idx]);
          chk("R4 location", int'(loc) == e_loc[idx], loc, e_loc[idx]);
          chk("R9 outside flag", int'(loc_na) == e_na[idx], loc_na, e_na[idx]);
        end else chk("R5 extra root", 1'b0, idx + 1, n_exp);
        idx++;
      end
      if (done) begin
        seen = 1;
        chk("R6 R7 done cycle", k == done_k, k, done_k);
        chk("R8 ok flag", int'(ok) == ok_exp, ok, ok_exp);
        chk("R2 busy drops", busy === 1'b0, busy, 0);
        break;
      end
    end
    chk("R7 done seen", seen, seen, 1);
    chk("R3 root count", idx == n_exp, idx, n_exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int dummy, elig, mode_sel;
    dummy = $urandom(20240611);
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy === 1'b0, busy, 0);
    chk("R1 reset strobe", loc_valid === 1'b0, loc_valid, 0);
    chk("R1 reset done", done === 1'b0, done, 0);
    rst_n = 1'b1;

    // R8: zero expected errors, empty locator
    nrt = 0; prepare(0, 0); launch(); collect();

    // R5 R9 R4: low root skipped, boundary root 104, top step 8191
    nrt = 4; rts[0] = 5; rts[1] = 104; rts[2] = 300; rts[3] = 8191;
    prepare(0, 3); launch(); collect();

    // R6: 8-error mode, stop early after two of three roots
    nrt = 3; rts[0] = 208; rts[1] = 1000; rts[2] = 4200;
    prepare(1, 2); launch(); collect();

    // R7: more expected than present -> failure after full range
    nrt = 2; rts[0] = 250; rts[1] = 3000;
    prepare(1, 3); launch(); collect();

    // R10: restart while first search still has roots ahead
    nrt = 3; rts[0] = 120; rts[1] = 130; rts[2] = 140;
    prepare(0, 3); launch();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      chk("R10 no early done", done === 1'b0, done, 0);
    end
    nrt = 2; rts[0] = 220; rts[1] = 231;
    prepare(1, 2); launch(); collect();

    // R3 R4: random locators
    for (int it = 0; it < 9; it++) begin
      bit m8 = 1'($urandom_range(0, 1));
      int tmax = m8 ? 8 : 4;
      nrt = $urandom_range(1, tmax);
      for (int r = 0; r < nrt; r++) begin
        bit dup;
        do begin
          rts[r] = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 400) : $urandom_range(1, 8191);
          dup = 0;
          for (int q = 0; q < r; q++) if (rts[q] == rts[r]) dup = 1;
        end while (dup);
      end
      elig = 0;
      for (int r = 0; r < nrt; r++) if (rts[r] >= (m8 ? 208 : 104)) elig++;
      mode_sel = $urandom_range(0, 3);
      if (mode_sel == 2) elig = elig + 1;
      else if (mode_sel == 3 && elig > 0) elig = elig - 1;
      prepare(m8, elig); launch(); collect();
    end

    summary();
    $finish;
  end
endmodule